// File: doc/BRIEF.md
# IR Receive Code FIFO with Interrupt Status

This block sits behind an infrared pulse encoder and stores the 8-bit run-length codes it produces until software collects them. Codes arrive on a valid/data pair and are held in a first-in-first-out store whose depth is a build parameter (16 or 64). Software reaches the block through a small register bus. A read of the data register returns the oldest code and removes it. The status register holds three sticky event flags and the live fill count. The interrupt-enable register masks each flag onto a single interrupt line and also holds a fill-level trigger.

The three flags mark a code lost because the store was full, a packet-end pulse from the encoder, and a fill count above the trigger level. Each flag stays set until software writes a one to its bit. The interrupt line is high while any flag is set whose enable is also set.

Top module: `ir_rx_fifo`

## Requirements
- R1: After reset the fill count, all flags, all enables and `irq_o` are zero, and a status read returns 0.
- R2: Each `code_valid_i` pulse stores `code_i` unless the store is full. Reads of offset 0x20 return the codes oldest first, and each such read removes one code.
- R3: A read of offset 0x20 while the store is empty returns 0 and leaves the count unchanged.
- R4: A code that arrives while the store is full, in a cycle with no removal, is dropped and the stored codes are left intact. The overflow flag (status bit 0) is set in the next cycle.
- R5: When the store is full and a code arrives in the same cycle as a read of the data register, the code is accepted, the count stays at the depth, and no overflow is flagged.
- R6: A `pkt_end_i` pulse sets the packet-end flag (status bit 1) in the next cycle.
- R7: The data-available flag (status bit 4) sets one cycle after a cycle in which the count is greater than the trigger level. The trigger level is held in interrupt-enable bits starting at bit 8.
- R8: Status bits starting at bit 8 give the live fill count, in a field log2(depth)+1 bits wide.
- R9: A write to status offset 0x30 clears every flag whose bit is written as 1 and leaves flags written as 0. If a flag's set condition holds in the same cycle, the set wins. A flag stays set after its cause goes away.
- R10: `irq_o` is high exactly when some flag is set and its enable is set. The enables are interrupt-enable bit 0 for overflow, bit 1 for packet end and bit 4 for data available.
- R11: The interrupt-enable register at offset 0x2C reads back what was written to its fields. Reads of unmapped offsets return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_valid_i | input | 1 | Encoder code strobe |
| code_i | input | 8 | Run-length code |
| pkt_end_i | input | 1 | Encoder packet-end pulse |
| addr_i | input | 6 | Register byte offset |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| re_i | input | 1 | Register read strobe (a read of the data register removes one code) |
| rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational. It reflects the state left by the previous clock edge and the address presented in the same cycle. A removal, a stored code or a count change appears in the next cycle. The flags and `irq_o` need one edge after their cause. The data-available flag is judged on the count held before that edge, so it shows one cycle after the count has crossed the level. The bench drives every input just after the falling edge. One nanosecond later it compares `rdata_o` and `irq_o` against a queue-based model, and only then advances the model by one clock. Each comparison therefore lands in the cycle when the result is due.

// File: rtl/ir_fifo_pkg.sv
package ir_fifo_pkg;
  localparam logic [5:0] OFF_DATA = 6'h20;
  localparam logic [5:0] OFF_IEN  = 6'h2C;
  localparam logic [5:0] OFF_STAT = 6'h30;
  localparam int NFLG  = 3;
  localparam int B_FLD = 8;
  // flag index -> register bit: overflow 0, packet end 1, data available 4
  localparam int FLG_OVF = 0;
  localparam int FLG_PKT = 1;
  localparam int FLG_AVL = 2;
  function automatic int flag_bit(input int idx);
    return (idx == FLG_AVL) ? 4 : idx;
  endfunction
endpackage

// File: rtl/code_fifo.sv
module code_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             drop_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic empty, full, pop_ok, push_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_i & ~empty;
  assign push_ok = push_i & (~full | pop_ok);
  assign drop_o  = push_i & full & ~pop_ok;
  assign dout_o  = empty ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r3_empty_pop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> $stable(cnt_q));
  a_r5_full_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full) |=> (cnt_q == CNT_W'(DEPTH)));
  a_r4_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NF = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] flag_o,
  output logic          irq_o
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~clr_i[i]) | set_i[i];
    end
    assign flag_o[i] = flag_q;

    a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q);
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i[i]) |=> flag_q);
  end

  assign irq_o = |(flag_o & en_i);

  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o != '0));
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo
  import ir_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        code_valid_i,
  input  logic [7:0]  code_i,
  input  logic        pkt_end_i,
  input  logic [5:0]  addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        re_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic [7:0]       dout;
  logic [CNT_W-1:0] count, lvl_q;
  logic [NFLG-1:0]  en_q, set, clr, flag;
  logic             drop, pop;

  assign pop = re_i & (addr_i == OFF_DATA);

  code_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (code_valid_i),
    .din_i  (code_i),
    .pop_i  (pop),
    .dout_o (dout),
    .count_o(count),
    .drop_o (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (we_i && addr_i == OFF_IEN) begin
      for (int i = 0; i < NFLG; i++) en_q[i] <= wdata_i[flag_bit(i)];
      lvl_q <= wdata_i[B_FLD +: CNT_W];
    end
  end

  always_comb begin
    set          = '0;
    set[FLG_OVF] = drop;
    set[FLG_PKT] = pkt_end_i;
    set[FLG_AVL] = (count > lvl_q);
    for (int i = 0; i < NFLG; i++)
      clr[i] = we_i & (addr_i == OFF_STAT) & wdata_i[flag_bit(i)];
  end

  irq_status #(.NF(NFLG)) u_stat (
    .clk_i, .rst_ni,
    .set_i (set),
    .clr_i (clr),
    .en_i  (en_q),
    .flag_o(flag),
    .irq_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        OFF_DATA: rdata_o[7:0] = dout;
        OFF_IEN: begin
          for (int i = 0; i < NFLG; i++) rdata_o[flag_bit(i)] = en_q[i];
          rdata_o[B_FLD +: CNT_W] = lvl_q;
        end
        OFF_STAT: begin
          for (int i = 0; i < NFLG; i++) rdata_o[flag_bit(i)] = flag[i];
          rdata_o[B_FLD +: CNT_W] = count;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  a_r6_pkt_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i |=> flag[FLG_PKT]);
  a_r7_avail_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count > lvl_q) |=> flag[FLG_AVL]);
  a_r4_ovf_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_i && count == CNT_W'(DEPTH) && !pop) |=> flag[FLG_OVF]);
endmodule

// File: tb/ir_rx_fifo_bench.sv
module ir_rx_fifo_bench;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic code_valid = 0, pkt_end = 0, we = 0, re = 0;
  logic [7:0]  code = 0;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;

  always #2 clk = ~clk;

  ir_rx_fifo #(.DEPTH(DEPTH)) u_ir_rx_fifo (
    .clk_i(clk), .rst_ni(rst_n), .code_valid_i(code_valid), .code_i(code),
    .pkt_end_i(pkt_end), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .irq_o(irq));

  int n_cmp = 0, n_bad = 0;
  string cur = "R1";

  // reference model
  byte unsigned q[$];
  bit m_ovf, m_pkt, m_avl, e_ovf, e_pkt, e_avl;
  int m_lvl;

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    if (!re) return v;
    case (addr)
      6'h20: v[7:0] = (q.size() > 0) ? q[0] : 8'h00;
      6'h2C: begin v[0] = e_ovf; v[1] = e_pkt; v[4] = e_avl; v[8 +: CW] = CW'(m_lvl); end
      6'h30: begin v[0] = m_ovf; v[1] = m_pkt; v[4] = m_avl; v[8 +: CW] = CW'(q.size()); end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit pop, sov, sav, spk;
    int old_n = q.size();
    pop = re && addr == 6'h20 && q.size() > 0;
    sav = old_n > m_lvl;
    spk = pkt_end;
    sov = 0;
    if (pop) void'(q.pop_front());
    if (code_valid) begin
      if (old_n == DEPTH && !pop) sov = 1;
      else q.push_back(code);
    end
    if (we && addr == 6'h30) begin
      if (wdata[0]) m_ovf = 0;
      if (wdata[1]) m_pkt = 0;
      if (wdata[4]) m_avl = 0;
    end
    m_ovf |= sov; m_pkt |= spk; m_avl |= sav;
    if (we && addr == 6'h2C) begin
      e_ovf = wdata[0]; e_pkt = wdata[1]; e_avl = wdata[4];
      m_lvl = int'(wdata[8 +: CW]);
    end
  endtask

  // one cycle: drive after negedge, compare, advance model, wait next negedge
  task automatic cyc(bit r, bit w, logic [5:0] a, logic [31:0] d,
                     bit cv, logic [7:0] c, bit pe);
    re = r; we = w; addr = a; wdata = d; code_valid = cv; code = c; pkt_end = pe;
    #1;
    check({cur, " rdata"}, rdata, exp_rd());
    check({"R10 irq in ", cur}, {31'b0, irq},
          {31'b0, (m_ovf & e_ovf) | (m_pkt & e_pkt) | (m_avl & e_avl)});
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();              cyc(0, 0, 6'h00, 0, 0, 0, 0); endtask
  task automatic rd(logic [5:0] a);   cyc(1, 0, a, 0, 0, 0, 0); endtask
  task automatic wr(logic [5:0] a, logic [31:0] d); cyc(0, 1, a, d, 0, 0, 0); endtask
  task automatic push(logic [7:0] c); cyc(0, 0, 6'h00, 0, 1, c, 0); endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        cur = "R1"; rd(6'h30); rd(6'h2C); idle();
        // R11: enable readback, unmapped offsets
        cur = "R11";
        wr(6'h2C, 32'h0000_0713); rd(6'h2C);
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h00); rd(6'h10); rd(6'h34); rd(6'h2C);
        // R2 / R8: order and live count
        cur = "R2";
        for (int i = 0; i < 5; i++) push(8'h80 + 8'(i));
        cur = "R8"; rd(6'h30);
        cur = "R2";
        for (int i = 0; i < 5; i++) rd(6'h20);
        // R3: empty reads
        cur = "R3"; rd(6'h20); rd(6'h20); rd(6'h30);
        // R7: level crossing, level 7
        cur = "R7";
        for (int i = 0; i < 9; i++) begin push(8'(i * 3)); rd(6'h30); end
        idle(); rd(6'h30);
        // R9: clear while condition holds (set wins), then drain and clear
        cur = "R9";
        wr(6'h30, 32'h10); rd(6'h30);
        for (int i = 0; i < 9; i++) rd(6'h20);
        idle(); wr(6'h30, 32'h10); rd(6'h30);
        // R4: overflow
        cur = "R4";
        for (int i = 0; i < DEPTH + 2; i++) push(8'h40 + 8'(i));
        rd(6'h30);
        // R5: push and pop in same full cycle
        cur = "R5";
        wr(6'h30, 32'hFF); rd(6'h30);
        cyc(1, 0, 6'h20, 0, 1, 8'hEE, 0); rd(6'h30);
        for (int i = 0; i < DEPTH; i++) rd(6'h20);
        rd(6'h20);
        // R6: packet end
        cur = "R6";
        wr(6'h30, 32'hFF);
        cyc(0, 0, 6'h00, 0, 0, 0, 1); rd(6'h30); idle(); rd(6'h30);
        // R9: zero write keeps, one write clears only that flag
        cur = "R9";
        push(8'h11); push(8'h22);
        for (int i = 0; i < DEPTH + 1; i++) push(8'h33);
        wr(6'h30, 32'h0); rd(6'h30);
        wr(6'h30, 32'h2); rd(6'h30);
        // R10: masking
        cur = "R10";
        wr(6'h2C, 32'h0000_0F00); rd(6'h30); idle();
        wr(6'h2C, 32'h0000_0F01); idle();
        wr(6'h30, 32'hFF); idle(); idle();
        cyc(0, 0, 6'h00, 0, 0, 0, 1);
        wr(6'h2C, 32'h0000_0F02); idle(); rd(6'h30);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule